// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between a UART receiver's deserializer and a register-mapped bus slave. Each completed 8-bit character arrives on a one-cycle strobe. The block holds it until a bus master reads it through a 32-bit receive-data word. That word is reachable at sixteen word-spaced alias addresses, so a master can drain several characters with one incrementing burst. Every read at any alias consumes one character.

A runtime control bit picks the buffering mode. With the bit low, a single holding slot keeps the latest character, and an unread character is overwritten by the next arrival. With the bit high, a ring buffer keeps up to `DEPTH` characters in arrival order, and an arrival into a full buffer is thrown away. Both kinds of loss raise a sticky overrun flag. A data-ready flag tells software when the receive word carries valid data. Any change of the mode bit empties the buffer.

Top module: `uart_rx_buffer`

## Requirements
- R1: `rd_data` bits 31:8 are always zero. While `bus_addr` hits an alias and `data_ready` is high, bits 7:0 carry the oldest unread character. When `bus_addr` is not an alias, `rd_data` is zero.
- R2: The alias addresses are the byte offsets 0x30, 0x34, ... 0x6C (sixteen, step 4). A `bus_rd` at any of them consumes one character. A `bus_rd` at any other address, a misaligned one included, consumes nothing.
- R3: `data_ready` is high in the cycle after an arrival. It stays high while at least one unread character is held, and it drops after the read that takes the last one.
- R4: With `fifo_en` = 0, one character is held. An arrival while one is unread replaces it and sets `overrun_err`.
- R5: With `fifo_en` = 1, up to 16 characters are held and are read back in the order they arrived.
- R6: With `fifo_en` = 1 and 16 held, an arrival without a read in the same cycle is discarded. The stored characters are kept and `overrun_err` is set.
- R7: A read and an arrival in the same cycle, while the buffer is at capacity in either mode, act as a read followed by a write. No overrun is raised.
- R8: `overrun_err` stays high until an `ovr_clr` pulse clears it. If a new overrun and `ovr_clr` fall in the same cycle, the flag stays set.
- R9: A cycle in which `fifo_en` differs from the mode in use empties the buffer. Any arrival or read in that cycle is ignored, and `data_ready` is low in the next cycle.
- R10: Reset empties the buffer, clears `overrun_err` and selects the single-slot mode.
- R11: A read while nothing is held has no effect. `data_ready` stays low and the next arrival is read back normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a received character is on `rx_char` |
| rx_char | input | 8 | Received character |
| fifo_en | input | 1 | 1 = ring-buffer mode, 0 = single-slot mode |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Bus byte address |
| ovr_clr | input | 1 | Clears the overrun flag (status register read) |
| rd_data | output | 32 | Receive-data word |
| data_ready | output | 1 | At least one unread character is held |
| overrun_err | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults: a depth of 16, an 8-bit bus address, and the alias window at 0x30 with sixteen slots of stride 4. A fill to capacity therefore takes only sixteen arrivals. This puts the full-buffer drop, the read-plus-arrival at capacity and a complete in-order drain within a short run. With the 8-bit address, the first alias (0x30), the last alias (0x6C), the word just past the window (0x70) and a misaligned address inside it (0x32) can all be reached. The single-slot overwrite, the mode-change flush and reads on an empty buffer are covered by the table walk and by directed cases.

// File: rtl/urb_pkg.sv
package urb_pkg;

  // Per-cycle action taken by the character store.
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,     // append an arrival
    OP_POP,      // consume the head
    OP_SWAP,     // consume the head and append an arrival
    OP_REPLACE,  // single slot: overwrite the held character
    OP_DROP,     // ring full: discard the arrival
    OP_FLUSH     // mode change: empty everything
  } buf_op_t;

  // Chooses the store action. A read on an empty store counts as no read.
  function automatic buf_op_t pick_op(input logic flush, input logic arrive,
                                      input logic take, input logic empty,
                                      input logic at_cap, input logic single);
    logic take_eff;
    take_eff = take && !empty;
    if (flush)                  return OP_FLUSH;
    if (arrive && take_eff)     return OP_SWAP;
    if (arrive && !at_cap)      return OP_PUSH;
    if (arrive && single)       return OP_REPLACE;
    if (arrive)                 return OP_DROP;
    if (take_eff)               return OP_POP;
    return OP_IDLE;
  endfunction

  function automatic logic is_overrun(input buf_op_t op);
    return (op == OP_REPLACE) || (op == OP_DROP);
  endfunction

endpackage

// File: rtl/urb_alias_decode.sv
module urb_alias_decode #(
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h30,
  parameter int SLOTS  = 16,
  parameter int STRIDE = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int LAST = BASE + (SLOTS - 1) * STRIDE;

  logic [ADDR_W-1:0] rel;
  logic              in_range;
  logic              aligned;

  assign rel      = addr - ADDR_W'(BASE);
  assign in_range = (addr >= ADDR_W'(BASE)) && (addr <= ADDR_W'(LAST));
  assign aligned  = (rel % ADDR_W'(STRIDE)) == '0;
  assign hit      = in_range && aligned;
endmodule

// File: rtl/urb_store.sv
module urb_store
  import urb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  buf_op_t           op,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    case (op)
      OP_PUSH, OP_SWAP: mem[wr_ptr] <= wr_data;
      OP_REPLACE:       mem[rd_ptr] <= wr_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      case (op)
        OP_PUSH: begin
          wr_ptr <= ptr_inc(wr_ptr);
          level  <= level + 1'b1;
        end
        OP_POP: begin
          rd_ptr <= ptr_inc(rd_ptr);
          level  <= level - 1'b1;
        end
        OP_SWAP: begin
          wr_ptr <= ptr_inc(wr_ptr);
          rd_ptr <= ptr_inc(rd_ptr);
        end
        OP_FLUSH: begin
          wr_ptr <= '0;
          rd_ptr <= '0;
          level  <= '0;
        end
        default: ;
      endcase
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/urb_flags.sv
module urb_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_evt,
  input  logic ovr_clr,
  output logic overrun_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun_err <= 1'b0;
    else if (ovr_evt) overrun_err <= 1'b1;
    else if (ovr_clr) overrun_err <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import urb_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int DATA_W       = 8,
  parameter int WORD_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int ALIAS_BASE   = 'h30,
  parameter int ALIAS_SLOTS  = 16,
  parameter int ALIAS_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              fifo_en,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ovr_clr,
  output logic [WORD_W-1:0] rd_data,
  output logic              data_ready,
  output logic              overrun_err
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              mode_q;     // mode in use: 1 = ring buffer
  logic              mode_chg;   // request differs from mode in use
  logic              hit;        // address decodes to an alias
  logic              take;       // read at an alias
  logic              at_cap;
  logic [CNT_W-1:0]  level;
  logic [CNT_W-1:0]  cap;
  logic [DATA_W-1:0] head;
  logic              ovr_evt;
  buf_op_t           op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;
  end

  assign mode_chg = fifo_en != mode_q;

  urb_alias_decode #(
    .ADDR_W(ADDR_W), .BASE(ALIAS_BASE), .SLOTS(ALIAS_SLOTS), .STRIDE(ALIAS_STRIDE)
  ) u_dec (
    .addr(bus_addr),
    .hit (hit)
  );

  assign take    = bus_rd && hit;
  assign cap     = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
  assign at_cap  = level >= cap;
  assign op      = pick_op(mode_chg, rx_valid, take, level == '0, at_cap, !mode_q);
  assign ovr_evt = is_overrun(op);

  urb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .wr_data(rx_char),
    .head   (head),
    .level  (level)
  );

  urb_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovr_evt    (ovr_evt),
    .ovr_clr    (ovr_clr),
    .overrun_err(overrun_err)
  );

  assign data_ready = level != '0;
  assign rd_data    = hit ? {{(WORD_W - DATA_W){1'b0}}, head} : '0;
endmodule

// File: rtl/urb_checker.sv
module urb_checker #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int WORD_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              bus_rd,
  input logic              ovr_clr,
  input logic              hit,
  input logic              mode_q,
  input logic              mode_chg,
  input logic [CNT_W-1:0]  level,
  input logic [WORD_W-1:0] rd_data,
  input logic              data_ready,
  input logic              overrun_err
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[WORD_W-1:DATA_W] == '0);

  assert_miss_no_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit && !rx_valid && !mode_chg) |=> $stable(level));

  assert_arrival_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mode_chg) |=> data_ready);

  assert_single_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (level <= CNT_W'(1)));

  assert_ring_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !mode_chg && level == CNT_W'(DEPTH) && rx_valid && !(bus_rd && hit))
      |=> (level == CNT_W'(DEPTH) && overrun_err));

  assert_swap_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrun_err && rx_valid && bus_rd && hit && data_ready && !mode_chg)
      |=> !overrun_err);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_err && !ovr_clr) |=> overrun_err);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !data_ready);
endmodule

bind uart_rx_buffer urb_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .bus_rd     (bus_rd),
  .ovr_clr    (ovr_clr),
  .hit        (hit),
  .mode_q     (mode_q),
  .mode_chg   (mode_chg),
  .level      (level),
  .rd_data    (rd_data),
  .data_ready (data_ready),
  .overrun_err(overrun_err)
);

// File: tb/uart_rx_buffer_test.sv
module uart_rx_buffer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        fifo_en = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        ovr_clr = 1'b0;
  logic [31:0] rd_data;
  logic        data_ready;
  logic        overrun_err;

  int checks = 0;
  int failures = 0;
  logic [31:0] seen;   // rd_data captured before the edge
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_rx_buffer uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .fifo_en(fifo_en), .bus_rd(bus_rd), .bus_addr(bus_addr), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .data_ready(data_ready), .overrun_err(overrun_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Starts at a falling edge; inputs are held for one rising edge.
  task automatic cyc(input logic v, input logic [7:0] c, input logic r,
                     input logic [7:0] a, input logic k);
    rx_valid = v; rx_char = c; bus_rd = r; bus_addr = a; ovr_clr = k;
    #2;
    seen = rd_data;
    @(posedge clk);
    #1;
    @(negedge clk);
    rx_valid = 0; bus_rd = 0; ovr_clr = 0;
  endtask

  // {rx, char[8], rd, addr[8], clr, chk_data, exp_ready, exp_ovr, exp_data[8]}
  localparam int NV = 11;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},  // R3 arrival
    {1'b0, 8'h00, 1'b1, 8'h30, 1'b0, 1'b1, 1'b0, 1'b0, 8'h11},  // R1 R2 first alias
    {1'b1, 8'hA5, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b1, 8'h3C, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00},  // R4 overwrite
    {1'b0, 8'h00, 1'b1, 8'h6C, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C},  // R4 R2 last alias
    {1'b0, 8'h00, 1'b1, 8'h70, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00},  // R1 outside window
    {1'b1, 8'h77, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},  // R8 clear
    {1'b1, 8'h88, 1'b1, 8'h34, 1'b0, 1'b1, 1'b1, 1'b0, 8'h77},  // R7 single slot
    {1'b0, 8'h00, 1'b1, 8'h32, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},  // R2 misaligned
    {1'b0, 8'h00, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 8'h88},  // R2 R3 last read
    {1'b0, 8'h00, 1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}   // R11 empty read
  };

  initial begin
    logic [7:0] chars [16];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 ready after reset", {31'b0, data_ready}, 32'd0);
    check("R10 overrun after reset", {31'b0, overrun_err}, 32'd0);
    bus_addr = 8'h40; #1;
    check("R1 upper bits zero", {8'b0, rd_data[31:8]}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][29], VEC[i][28:21], VEC[i][20], VEC[i][19:12], VEC[i][11]);
      if (VEC[i][10]) check($sformatf("R1 vec%0d data", i), seen, {24'b0, VEC[i][7:0]});
      check($sformatf("R3 vec%0d ready", i), {31'b0, data_ready}, {31'b0, VEC[i][9]});
      check($sformatf("R8 vec%0d overrun", i), {31'b0, overrun_err}, {31'b0, VEC[i][8]});
    end

    // R8: a new overrun wins over a clear in the same cycle
    cyc(1, 8'h10, 0, 8'h00, 0);
    cyc(1, 8'h20, 0, 8'h00, 1);
    check("R8 set beats clear", {31'b0, overrun_err}, 32'd1);
    cyc(0, 8'h00, 0, 8'h00, 1);
    check("R8 clear pulse", {31'b0, overrun_err}, 32'd0);
    cyc(0, 8'h00, 1, 8'h50, 0);
    check("R4 replaced char", seen, 32'h20);

    // R5 R6 R7 ring mode
    fifo_en = 1'b1;
    cyc(0, 8'h00, 0, 8'h00, 0);
    check("R9 empty after switch", {31'b0, data_ready}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      chars[k] = 8'(k * 7 + 3);
      cyc(1, chars[k], 0, 8'h00, 0);
    end
    check("R5 ready when full", {31'b0, data_ready}, 32'd1);
    check("R5 no overrun at 16", {31'b0, overrun_err}, 32'd0);
    cyc(1, 8'hEE, 0, 8'h00, 0);
    check("R6 overrun on full", {31'b0, overrun_err}, 32'd1);
    cyc(0, 8'h00, 0, 8'h00, 1);
    cyc(1, 8'h99, 1, 8'h44, 0);
    check("R7 head on swap", seen, {24'b0, chars[0]});
    check("R7 no overrun on swap", {31'b0, overrun_err}, 32'd0);
    for (int k = 1; k < 16; k++) begin
      cyc(0, 8'h00, 1, 8'(8'h30 + 4 * k), 0);
      check($sformatf("R5 order %0d", k), seen, {24'b0, chars[k]});
    end
    cyc(0, 8'h00, 1, 8'h30, 0);
    check("R6 kept arrival after swap", seen, 32'h99);
    check("R3 ready drops at empty", {31'b0, data_ready}, 32'd0);

    // R9 flush, arrival in the switching cycle ignored
    cyc(1, 8'h41, 0, 8'h00, 0);
    cyc(1, 8'h42, 0, 8'h00, 0);
    fifo_en = 1'b0;
    cyc(1, 8'h43, 0, 8'h00, 0);
    check("R9 flushed", {31'b0, data_ready}, 32'd0);

    // R11 read on empty then normal use
    cyc(0, 8'h00, 1, 8'h30, 0);
    check("R11 still empty", {31'b0, data_ready}, 32'd0);
    check("R11 no overrun", {31'b0, overrun_err}, 32'd0);
    cyc(1, 8'h55, 0, 8'h00, 0);
    cyc(0, 8'h00, 1, 8'h38, 0);
    check("R11 next arrival read", seen, 32'h55);

    // R10 reset mid-run
    cyc(1, 8'h66, 0, 8'h00, 0);
    cyc(1, 8'h67, 0, 8'h00, 0);
    rst_n = 1'b0; #2;
    check("R10 ready in reset", {31'b0, data_ready}, 32'd0);
    check("R10 overrun in reset", {31'b0, overrun_err}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule